// File: doc/BRIEF.md
# Stereo DAC Channel Routing Mixer

This block sits between a serial audio receiver and a stereo DAC pair. For every incoming stereo pair it builds the two samples sent to the converters. The left output and the right output each have their own source. A source is one of four: silence, the incoming left sample, the incoming right sample, or the mono average of the two. A 4-bit routing word picks the source for each output.

Samples are signed two's complement. The width is a parameter. Results leave through a register stage together with a valid strobe. The routing word is taken in the same cycle as the input strobe, so a routing change always applies to a whole stereo pair and never to half of one. All sixteen routing words are legal. That includes the same source on both outputs, a channel swap, and mono on both outputs.

Top module: `stereo_route_mix`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high. `out_valid` is low one cycle after any cycle with `in_valid` low.
- R2: `route_cfg[1:0]` selects the source of `out_left` and `route_cfg[3:2]` selects the source of `out_right`. The codes are 2'b00 silence, 2'b01 input left, 2'b10 input right and 2'b11 average.
- R3: A silenced output is exactly zero.
- R4: The average is the (W+1)-bit sum of the two inputs shifted right arithmetically by one bit. It never overflows, even with both inputs at full scale positive or full scale negative, and it always lies between the two inputs.
- R5: An odd sum is rounded toward negative infinity. For example, inputs 1 and 2 give 1, inputs -1 and -2 give -2, and inputs -5 and 2 give -2.
- R6: The two selectors act independently and every one of the 16 routing words is legal, including duplicate sources and mono on both outputs.
- R7: In a cycle with `in_valid` low, changes on `in_left`, `in_right` and `route_cfg` have no effect. The output samples hold their last values.
- R8: While reset is active, and after it until the first strobe, `out_valid`, `out_left` and `out_right` are zero.
- R9: Routing word 4'b1001 is the straight setting. It sends the input left to the left output and the input right to the right output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe marking a new stereo input pair |
| in_left | input | W | Signed left input sample |
| in_right | input | W | Signed right input sample |
| route_cfg | input | 4 | Routing word: [1:0] left source, [3:2] right source |
| out_valid | output | 1 | Strobe for the output pair, one cycle after the input strobe |
| out_left | output | W | Signed sample for the left DAC |
| out_right | output | W | Signed sample for the right DAC |

## Verification
The bench sweeps all sixteen routing words with two sample pairs. The first pair has clearly different magnitudes and opposite signs, so a swapped selector bit or a left/right mix-up shows up as a wrong value. The second pair has an odd negative sum, which separates floor rounding from truncation toward zero. Full-scale pairs of the same sign, and a full-scale pair of opposite signs, separate a (W+1)-bit sum from a wrapping W-bit sum. Back-to-back strobes that change the routing word on every cycle check that each pair takes its own word. A burst of idle-cycle changes on every input shows whether anything leaks through without a strobe.

// File: rtl/route_mix_pkg.sv
package route_mix_pkg;

    localparam int SEL_W = 2;
    localparam int CH_N  = 2;
    localparam int CFG_W = SEL_W * CH_N;

    typedef enum logic [SEL_W-1:0] {
        SRC_SILENT = 2'b00,
        SRC_LEFT   = 2'b01,
        SRC_RIGHT  = 2'b10,
        SRC_MEAN   = 2'b11
    } src_sel_e;

endpackage

// File: rtl/mix_mean.sv
module mix_mean #(
    parameter int W = 24
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] mean
);
    localparam int SUM_W = W + 1;

    logic signed [SUM_W-1:0] sum;

    always_comb begin
        sum = $signed({a[W-1], a}) + $signed({b[W-1], b});
    end

    // arithmetic shift right by one of the widened sum: floor division by two
    assign mean = sum[SUM_W-1:1];
endmodule

// File: rtl/mix_pick.sv
module mix_pick
    import route_mix_pkg::*;
#(
    parameter int W = 24
) (
    input  src_sel_e            sel,
    input  logic signed [W-1:0] left,
    input  logic signed [W-1:0] right,
    input  logic signed [W-1:0] mean,
    output logic signed [W-1:0] pick
);
    always_comb begin
        case (sel)
            SRC_LEFT:  pick = left;
            SRC_RIGHT: pick = right;
            SRC_MEAN:  pick = mean;
            default:   pick = '0;
        endcase
    end
endmodule

// File: rtl/stereo_route_mix.sv
module stereo_route_mix
    import route_mix_pkg::*;
#(
    parameter int W = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic signed [W-1:0]    in_left,
    input  logic signed [W-1:0]    in_right,
    input  logic [CFG_W-1:0]       route_cfg,
    output logic                   out_valid,
    output logic signed [W-1:0]    out_left,
    output logic signed [W-1:0]    out_right
);
    typedef struct packed {
        logic                valid;
        logic signed [W-1:0] left;
        logic signed [W-1:0] right;
    } pair_t;

    pair_t st_d, st_q;

    logic signed [W-1:0] mean_w;
    logic signed [W-1:0] pick_w [CH_N];

    mix_mean #(.W(W)) u_mean (
        .a    (in_left),
        .b    (in_right),
        .mean (mean_w)
    );

    for (genvar g = 0; g < CH_N; g++) begin : g_ch
        mix_pick #(.W(W)) u_pick (
            .sel   (src_sel_e'(route_cfg[g*SEL_W +: SEL_W])),
            .left  (in_left),
            .right (in_right),
            .mean  (mean_w),
            .pick  (pick_w[g])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.left  = pick_w[0];
            st_d.right = pick_w[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_left  = st_q.left;
    assign out_right = st_q.right;
endmodule

// File: rtl/mix_route_checker.sv
module mix_route_checker #(
    parameter int W = 24
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic signed [W-1:0] in_left,
    input logic signed [W-1:0] in_right,
    input logic [3:0]          route_cfg,
    input logic                out_valid,
    input logic signed [W-1:0] out_left,
    input logic signed [W-1:0] out_right
);
    logic signed [W-1:0] lo_w, hi_w;

    always_comb begin
        lo_w = (in_left < in_right) ? in_left : in_right;
        hi_w = (in_left < in_right) ? in_right : in_left;
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_ROUTE_LEFT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && route_cfg[1:0] == 2'b01) |=> out_left == $past(in_left)); // R2
    AST_ROUTE_RIGHT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && route_cfg[3:2] == 2'b10) |=> out_right == $past(in_right)); // R2
    AST_SILENT_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && route_cfg[1:0] == 2'b00) |=> out_left == '0); // R3
    AST_SILENT_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && route_cfg[3:2] == 2'b00) |=> out_right == '0); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && route_cfg[3:2] == 2'b11)
            |=> (out_right >= $past(lo_w) && out_right <= $past(hi_w))); // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_left) && $stable(out_right))); // R7
    AST_STRAIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && route_cfg == 4'b1001)
            |=> (out_left == $past(in_left) && out_right == $past(in_right))); // R9
endmodule

bind stereo_route_mix mix_route_checker #(.W(W)) u_chk (.*);

// File: tb/stereo_route_mix_bench.sv
module stereo_route_mix_bench;
    localparam int W = 24;
    localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic signed [W-1:0] in_left = '0;
    logic signed [W-1:0] in_right = '0;
    logic [3:0]          route_cfg = 4'b0000;
    logic                out_valid;
    logic signed [W-1:0] out_left;
    logic signed [W-1:0] out_right;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic signed [W-1:0] l;
        logic signed [W-1:0] r;
        string               tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t last_exp;

    always #4 clk = ~clk;

    stereo_route_mix #(.W(W)) u_stereo_route_mix (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right), .route_cfg(route_cfg),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
    );

    function automatic logic signed [W-1:0] ref_pick(input logic [1:0] sel,
            input logic signed [W-1:0] l, input logic signed [W-1:0] r);
        longint s;
        s = longint'(l) + longint'(r);
        case (sel)
            2'b01:   return l;
            2'b10:   return r;
            2'b11:   return (s >= 0) ? W'(s / 2) : W'(-((-s + 1) / 2));
            default: return '0;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    task automatic send(input logic signed [W-1:0] l, input logic signed [W-1:0] r,
                        input logic [3:0] cfg, input string tag);
        exp_t e;
        @(negedge clk);
        in_left   = l;
        in_right  = r;
        route_cfg = cfg;
        in_valid  = 1'b1;
        e.l   = ref_pick(cfg[1:0], l, r);
        e.r   = ref_pick(cfg[3:2], l, r);
        e.tag = tag;
        exp_q.push_back(e);
        last_exp = e;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor: pops one expected pair per output strobe
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1", "out_valid high with nothing pending");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(out_left == e.l && out_right == e.r, e.tag,
                      $sformatf("got L=%0d R=%0d expected L=%0d R=%0d",
                                out_left, out_right, e.l, e.r));
            end
        end
    end

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            report();
        end
    end

    initial begin
        // R8: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && out_left == '0 && out_right == '0, "R8",
              $sformatf("during reset got v=%0b L=%0d R=%0d expected 0/0/0",
                        out_valid, out_left, out_right));
        rst_n = 1'b1;
        idle(2);
        check(out_valid == 1'b0 && out_left == '0 && out_right == '0, "R8",
              $sformatf("after reset got v=%0b L=%0d R=%0d expected 0/0/0",
                        out_valid, out_left, out_right));

        // R9: straight routing
        send(24'sd1193046, -24'sd703710, 4'b1001, "R9");
        idle(2);

        // R2 R3 R6: every routing word with two sample pairs
        for (int c = 0; c < 16; c++) begin
            send(24'sd1193046, -24'sd703710, 4'(c), "R2/R6");
            idle(1);
            send(-24'sd5, 24'sd2, 4'(c), "R3/R5");
            idle(1);
        end

        // R4: full-scale averages
        send(MAXV, MAXV, 4'b1111, "R4");
        send(MINV, MINV, 4'b1111, "R4");
        send(MAXV, MINV, 4'b1111, "R4");
        // R5: floor rounding of odd sums
        send(24'sd1, 24'sd2, 4'b1111, "R5");
        send(-24'sd1, -24'sd2, 4'b1111, "R5");
        idle(2);

        // R6: back-to-back strobes, word changes every pair
        send(24'sd100, 24'sd300, 4'b0110, "R6");
        send(24'sd100, 24'sd300, 4'b0101, "R6");
        send(24'sd100, 24'sd300, 4'b1010, "R6");
        send(24'sd100, 24'sd300, 4'b1100, "R6");
        idle(3);

        // R7: idle-cycle changes leave outputs alone
        send(24'sd4242, -24'sd17, 4'b0111, "R7");
        @(negedge clk);
        in_valid  = 1'b0;
        in_left   = 24'sd999;
        in_right  = 24'sd888;
        route_cfg = 4'b1010;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            in_left  = in_left + 24'sd7;
            route_cfg = route_cfg ^ 4'b0101;
        end
        check(out_valid == 1'b0 && out_left == last_exp.l && out_right == last_exp.r, "R7",
              $sformatf("held L=%0d R=%0d v=%0b expected L=%0d R=%0d v=0",
                        out_left, out_right, out_valid, last_exp.l, last_exp.r));
        check(exp_q.size() == 0, "R1",
              $sformatf("pending=%0d expected 0", exp_q.size()));

        done = 1'b1;
        report();
    end
endmodule